// File: doc/BRIEF.md
# Chunked DMA Transfer Sequencer

This block carries out a single, already validated copy job as a series of 32-byte chunks. For a job whose source is memory, each chunk begins with one 8-beat read burst on a dedicated memory port that bypasses the CPU cache. The chunk is held in a 32-byte internal buffer. It then goes to one of three places: back to memory as one 8-beat write burst, into an SPI transmit FIFO one byte at a time, or into a framebuffer write FIFO one word at a time. In the SPI-to-memory direction the block waits until the SPI receive FIFO holds a full chunk. It then drains 32 bytes and writes them to memory as one burst.

A port-select output grants each chunk phase to either the memory port or the peripheral port, so the two sides take turns for every chunk in the SPI and framebuffer directions. Once a chunk has been written, the memory-side addresses advance by 32 and the remaining count drops by 32. The peripheral-side address stays fixed. A one-cycle completion pulse marks the end of the job. Chip-select control, the SPI serializer and the memory controller are outside this block. The SPI peripheral number is passed through unchanged for the job's duration.

Top module: `dma_chunk_seq`

## Requirements
- R1: During and after reset, until a job is started, `job_busy` and `job_done` are low, `port_sel` is 0 (memory), and `mem_req`, `mem_wvalid`, `spi_tx_push`, `spi_rx_pop` and `fb_push` are all low.
- R2: `job_start` is taken only while idle. The job fields are latched at that edge and `job_busy` rises in the next cycle. A `job_start` pulse while busy has no effect on the data moved, the addresses written or the number of completions.
- R3: Mode 0 (memory to memory) copies `job_count` bytes. Chunk k is read from `job_src + 32k` and written to `job_dst + 32k`. Memory outside the destination range is not written.
- R4: `mem_req` stays high, with `mem_addr` and `mem_we` stable (`mem_we` = 1 for a write), until the cycle in which `mem_ack` is high. A read burst collects exactly 8 words, one on each cycle with `mem_rvalid` high, and gaps are allowed. A write burst drives `mem_wvalid` with one word on each of the 8 cycles after the acknowledge.
- R5: Mode 1 (memory to SPI) pushes each chunk's 32 bytes in order. Byte 4i+j is bits [8j+7:8j] of the chunk's word i. There is never a push in a cycle with `spi_tx_full` high, and `spi_id` holds the job's peripheral number while busy.
- R6: `port_sel` is 0 whenever `mem_req` or `mem_wvalid` is high, and 1 whenever a push or pop happens on a peripheral FIFO. In modes 1, 2 and 3 it therefore rises once per chunk.
- R7: Mode 2 (SPI to memory) starts no pop until `spi_rx_level` is at least 32. It then pops exactly 32 bytes, packs them with the same byte order as R5, and writes them as one burst to `job_dst + 32k`.
- R8: Mode 3 (memory to framebuffer) pushes 8 words per chunk. Word i of chunk k goes to `fb_addr = job_dst + 32k + 4i`. There is never a push in a cycle with `fb_full` high.
- R9: After the last chunk, `job_done` is high for exactly one cycle, the first cycle in which `job_busy` is low again.
- R10: A job of exactly 32 bytes moves one chunk and then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | Start pulse for a validated job |
| job_mode | input | 2 | 0 mem-to-mem, 1 mem-to-SPI, 2 SPI-to-mem, 3 mem-to-framebuffer |
| job_src | input | ADDR_W | Source byte address |
| job_dst | input | ADDR_W | Destination byte address |
| job_count | input | CNT_W | Byte count, a whole number of 32-byte chunks |
| job_spi_id | input | ID_W | SPI peripheral number |
| job_busy | output | 1 | High while a job runs |
| job_done | output | 1 | One-cycle completion pulse |
| port_sel | output | 1 | 0 memory port owns the phase, 1 peripheral port owns it |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | Burst is a write |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | DATA_W | Read data beat |
| mem_wvalid | output | 1 | Write data beat valid |
| mem_wdata | output | DATA_W | Write data beat |
| spi_id | output | ID_W | Peripheral number of the running job |
| spi_tx_push | output | 1 | Push a byte into the SPI transmit FIFO |
| spi_tx_data | output | 8 | Byte pushed |
| spi_tx_full | input | 1 | SPI transmit FIFO full |
| spi_rx_pop | output | 1 | Pop a byte from the SPI receive FIFO |
| spi_rx_data | input | 8 | Head byte of the receive FIFO |
| spi_rx_level | input | LVL_W | Bytes held in the receive FIFO |
| fb_push | output | 1 | Push a word into the framebuffer FIFO |
| fb_addr | output | ADDR_W | Framebuffer byte address of the word |
| fb_data | output | DATA_W | Word pushed |
| fb_full | input | 1 | Framebuffer FIFO full |

## Verification
On every cycle, the assertions check that the block never pushes into a full FIFO and never pops the receive FIFO before a chunk is present. They also check that a memory request holds its address and direction until it is acknowledged, that the port select agrees with whichever side is active, that an idle block is quiet, and that completion coincides with leaving busy. The directed scenarios are what show the data itself. They check byte ordering into and out of the SPI FIFOs, the per-chunk address steps on both memories and the framebuffer, and that the block waits with a partly filled receive FIFO. They also show that a start pulse during a job changes nothing and that a single-chunk job completes. Memory latency, read-beat gaps and full-flag stalls are varied across the scenarios.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        XFER_M2M   = 2'd0,
        XFER_M2SPI = 2'd1,
        XFER_SPI2M = 2'd2,
        XFER_M2FB  = 2'd3
    } xfer_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_BEAT,
        ST_WR_REQ,
        ST_WR_BEAT,
        ST_TX_BYTE,
        ST_RX_WAIT,
        ST_RX_BYTE,
        ST_FB_WORD,
        ST_STEP
    } seq_state_e;

endpackage

// File: rtl/dma_seq_line_buf.sv
module dma_seq_line_buf #(
    parameter  int DATA_W     = 32,
    parameter  int LINE_BYTES = 32,
    localparam int BPW        = DATA_W / 8,
    localparam int LANE_W     = $clog2(BPW),
    localparam int BYTE_IDX_W = $clog2(LINE_BYTES),
    localparam int WORD_IDX_W = BYTE_IDX_W - LANE_W
) (
    input  logic                  clk,
    input  logic                  word_we,
    input  logic [WORD_IDX_W-1:0] word_idx,
    input  logic [DATA_W-1:0]     word_wdata,
    input  logic                  byte_we,
    input  logic [BYTE_IDX_W-1:0] byte_idx,
    input  logic [7:0]            byte_wdata,
    output logic [DATA_W-1:0]     word_rdata,
    output logic [7:0]            byte_rdata
);

    logic [7:0] bytes_q [LINE_BYTES];
    logic [7:0] bytes_d [LINE_BYTES];

    always_comb begin
        bytes_d = bytes_q;
        if (word_we) begin
            for (int j = 0; j < BPW; j++) begin
                bytes_d[{word_idx, LANE_W'(j)}] = word_wdata[8*j +: 8];
            end
        end
        if (byte_we) begin
            bytes_d[byte_idx] = byte_wdata;
        end
    end

    always_ff @(posedge clk) begin
        bytes_q <= bytes_d;
    end

    // Little-endian lanes: byte lane j of a word is chunk byte {word, j}
    for (genvar j = 0; j < BPW; j++) begin : g_lane
        assign word_rdata[8*j +: 8] = bytes_q[{word_idx, LANE_W'(j)}];
    end

    assign byte_rdata = bytes_q[byte_idx];

endmodule

// File: rtl/dma_seq_stepper.sv
module dma_seq_stepper #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              adv_src_in,
    input  logic              adv_dst_in,
    input  logic              step,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic              last
);

    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(LINE_BYTES);
    localparam logic [CNT_W-1:0]  CNT_DEC  = CNT_W'(LINE_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  rem;
        logic              adv_src;
        logic              adv_dst;
    } step_t;

    step_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.src     = src_in;
            s_d.dst     = dst_in;
            s_d.rem     = cnt_in;
            s_d.adv_src = adv_src_in;
            s_d.adv_dst = adv_dst_in;
        end else if (step) begin
            if (s_q.adv_src) s_d.src = s_q.src + ADDR_INC;
            if (s_q.adv_dst) s_d.dst = s_q.dst + ADDR_INC;
            s_d.rem = (s_q.rem > CNT_DEC) ? s_q.rem - CNT_DEC : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign src  = s_q.src;
    assign dst  = s_q.dst;
    assign last = (s_q.rem <= CNT_DEC);

endmodule

// File: rtl/dma_chunk_seq.sv
module dma_chunk_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int LINE_BYTES = 32,
    parameter int LVL_W      = 8,
    parameter int ID_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_start,
    input  logic [1:0]        job_mode,
    input  logic [ADDR_W-1:0] job_src,
    input  logic [ADDR_W-1:0] job_dst,
    input  logic [CNT_W-1:0]  job_count,
    input  logic [ID_W-1:0]   job_spi_id,
    output logic              job_busy,
    output logic              job_done,
    output logic              port_sel,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wvalid,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ID_W-1:0]   spi_id,
    output logic              spi_tx_push,
    output logic [7:0]        spi_tx_data,
    input  logic              spi_tx_full,
    output logic              spi_rx_pop,
    input  logic [7:0]        spi_rx_data,
    input  logic [LVL_W-1:0]  spi_rx_level,
    output logic              fb_push,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [DATA_W-1:0] fb_data,
    input  logic              fb_full
);

    localparam int BPW        = DATA_W / 8;
    localparam int BEATS      = LINE_BYTES / BPW;
    localparam int LANE_W     = $clog2(BPW);
    localparam int BYTE_IDX_W = $clog2(LINE_BYTES);
    localparam int WORD_IDX_W = BYTE_IDX_W - LANE_W;
    localparam logic [BYTE_IDX_W-1:0] LAST_WORD = BYTE_IDX_W'(BEATS - 1);
    localparam logic [BYTE_IDX_W-1:0] LAST_BYTE = BYTE_IDX_W'(LINE_BYTES - 1);
    localparam logic [LVL_W-1:0]      RX_NEED   = LVL_W'(LINE_BYTES);

    typedef struct packed {
        seq_state_e             state;
        xfer_mode_e             mode;
        logic [ID_W-1:0]        id;
        logic [BYTE_IDX_W-1:0]  idx;
        logic                   done;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic                  ld, stp, last_chunk;
    logic                  buf_word_we, buf_byte_we;
    logic [ADDR_W-1:0]     cur_src, cur_dst;
    logic [DATA_W-1:0]     buf_word;
    logic [7:0]            buf_byte;
    logic [WORD_IDX_W-1:0] word_idx;
    logic                  idx_last_word, idx_last_byte;
    xfer_mode_e            req_mode;

    assign req_mode      = xfer_mode_e'(job_mode);
    assign word_idx      = r_q.idx[WORD_IDX_W-1:0];
    assign idx_last_word = (r_q.idx == LAST_WORD);
    assign idx_last_byte = (r_q.idx == LAST_BYTE);

    dma_seq_stepper #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .LINE_BYTES (LINE_BYTES)
    ) stepper_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .src_in     (job_src),
        .dst_in     (job_dst),
        .cnt_in     (job_count),
        .adv_src_in (req_mode != XFER_SPI2M),
        .adv_dst_in (req_mode != XFER_M2SPI),
        .step       (stp),
        .src        (cur_src),
        .dst        (cur_dst),
        .last       (last_chunk)
    );

    dma_seq_line_buf #(
        .DATA_W     (DATA_W),
        .LINE_BYTES (LINE_BYTES)
    ) line_buf_i (
        .clk        (clk),
        .word_we    (buf_word_we),
        .word_idx   (word_idx),
        .word_wdata (mem_rdata),
        .byte_we    (buf_byte_we),
        .byte_idx   (r_q.idx),
        .byte_wdata (spi_rx_data),
        .word_rdata (buf_word),
        .byte_rdata (buf_byte)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        ld          = 1'b0;
        stp         = 1'b0;
        buf_word_we = 1'b0;
        buf_byte_we = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (job_start) begin
                    ld        = 1'b1;
                    r_d.mode  = req_mode;
                    r_d.id    = job_spi_id;
                    r_d.idx   = '0;
                    r_d.state = (req_mode == XFER_SPI2M) ? ST_RX_WAIT : ST_RD_REQ;
                end
            end
            ST_RD_REQ: begin
                if (mem_ack) begin
                    r_d.state = ST_RD_BEAT;
                    r_d.idx   = '0;
                end
            end
            ST_RD_BEAT: begin
                if (mem_rvalid) begin
                    buf_word_we = 1'b1;
                    if (idx_last_word) begin
                        r_d.idx = '0;
                        unique case (r_q.mode)
                            XFER_M2SPI: r_d.state = ST_TX_BYTE;
                            XFER_M2FB:  r_d.state = ST_FB_WORD;
                            default:    r_d.state = ST_WR_REQ;
                        endcase
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_WR_REQ: begin
                if (mem_ack) begin
                    r_d.state = ST_WR_BEAT;
                    r_d.idx   = '0;
                end
            end
            ST_WR_BEAT: begin
                if (idx_last_word) begin
                    r_d.state = ST_STEP;
                    r_d.idx   = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_TX_BYTE: begin
                if (!spi_tx_full) begin
                    if (idx_last_byte) begin
                        r_d.state = ST_STEP;
                        r_d.idx   = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_RX_WAIT: begin
                if (spi_rx_level >= RX_NEED) begin
                    r_d.state = ST_RX_BYTE;
                    r_d.idx   = '0;
                end
            end
            ST_RX_BYTE: begin
                buf_byte_we = 1'b1;
                if (idx_last_byte) begin
                    r_d.state = ST_WR_REQ;
                    r_d.idx   = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_FB_WORD: begin
                if (!fb_full) begin
                    if (idx_last_word) begin
                        r_d.state = ST_STEP;
                        r_d.idx   = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_STEP: begin
                stp     = 1'b1;
                r_d.idx = '0;
                if (last_chunk) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.state = (r_q.mode == XFER_SPI2M) ? ST_RX_WAIT : ST_RD_REQ;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.mode  <= XFER_M2M;
            r_q.id    <= '0;
            r_q.idx   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign job_busy    = (r_q.state != ST_IDLE);
    assign job_done    = r_q.done;
    assign port_sel    = (r_q.state == ST_TX_BYTE) || (r_q.state == ST_RX_WAIT) ||
                         (r_q.state == ST_RX_BYTE) || (r_q.state == ST_FB_WORD);
    assign mem_req     = (r_q.state == ST_RD_REQ) || (r_q.state == ST_WR_REQ);
    assign mem_we      = (r_q.state == ST_WR_REQ);
    assign mem_addr    = (r_q.state == ST_WR_REQ) ? cur_dst : cur_src;
    assign mem_wvalid  = (r_q.state == ST_WR_BEAT);
    assign mem_wdata   = buf_word;
    assign spi_id      = r_q.id;
    assign spi_tx_push = (r_q.state == ST_TX_BYTE) && !spi_tx_full;
    assign spi_tx_data = buf_byte;
    assign spi_rx_pop  = (r_q.state == ST_RX_BYTE);
    assign fb_push     = (r_q.state == ST_FB_WORD) && !fb_full;
    assign fb_addr     = cur_dst + ADDR_W'({word_idx, {LANE_W{1'b0}}});
    assign fb_data     = buf_word;

endmodule

// File: rtl/dma_chunk_seq_chk.sv
module dma_chunk_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int LVL_W  = 8,
    parameter int ID_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              job_busy,
    input logic              job_done,
    input logic              port_sel,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_wvalid,
    input logic [ID_W-1:0]   spi_id,
    input logic              spi_tx_push,
    input logic              spi_tx_full,
    input logic              spi_rx_pop,
    input logic [LVL_W-1:0]  spi_rx_level,
    input logic              fb_push,
    input logic              fb_full
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !job_busy |-> !mem_req && !mem_wvalid && !spi_tx_push && !spi_rx_pop && !fb_push && !port_sel);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5
    tx_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_push |-> !spi_tx_full);

    // R8
    fb_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_push |-> !fb_full);

    // R7
    rx_chunk_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_rx_pop) |-> spi_rx_level >= LVL_W'(32));

    // R6
    port_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || mem_wvalid) |-> !port_sel);

    // R6
    port_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_tx_push || spi_rx_pop || fb_push) |-> port_sel);

    // R9
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |-> !job_busy && $past(job_busy));

    // R5
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_busy && $past(job_busy) |-> $stable(spi_id));

endmodule

bind dma_chunk_seq dma_chunk_seq_chk #(
    .ADDR_W (ADDR_W),
    .LVL_W  (LVL_W),
    .ID_W   (ID_W)
) chk_i (.*);

// File: tb/dma_chunk_seq_tb.sv
`timescale 1ns/1ps
module dma_chunk_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        job_start = 1'b0;
    logic [1:0]  job_mode = 2'd0;
    logic [31:0] job_src = '0, job_dst = '0, job_count = '0;
    logic [2:0]  job_spi_id = '0;
    logic        job_busy, job_done, port_sel;
    logic        mem_req, mem_we, mem_wvalid;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  spi_id;
    logic        spi_tx_push, spi_rx_pop, fb_push;
    logic [7:0]  spi_tx_data;
    logic        spi_tx_full = 1'b0, fb_full = 1'b0;
    logic [7:0]  spi_rx_data = '0;
    logic [7:0]  spi_rx_level;
    logic [31:0] fb_addr, fb_data;

    always #2.5 clk = ~clk;

    dma_chunk_seq dut_i (
        .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_mode(job_mode),
        .job_src(job_src), .job_dst(job_dst), .job_count(job_count), .job_spi_id(job_spi_id),
        .job_busy(job_busy), .job_done(job_done), .port_sel(port_sel),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata),
        .spi_id(spi_id), .spi_tx_push(spi_tx_push), .spi_tx_data(spi_tx_data), .spi_tx_full(spi_tx_full),
        .spi_rx_pop(spi_rx_pop), .spi_rx_data(spi_rx_data), .spi_rx_level(spi_rx_level),
        .fb_push(fb_push), .fb_addr(fb_addr), .fb_data(fb_data), .fb_full(fb_full)
    );

    int n_chk = 0, n_err = 0;

    // Environment models and knobs
    logic [31:0] mem [0:511];
    int  ack_lat = 0;
    bit  rgap = 0, tx_stall = 0, fb_stall = 0;
    int  cyc = 0;
    bit  ack_pend = 0, req_we = 0, gap_t = 0, rx_pend = 0, sel_prev = 0;
    int  ack_dly = 0, rd_left = 0;
    logic [8:0] rd_idx = '0, wr_idx = '0, req_idx = '0;
    logic [7:0] tx_log [0:255];
    int  tx_n = 0;
    logic [31:0] fb_la [0:63], fb_ld [0:63];
    int  fb_n = 0;
    logic [7:0] rx_q [0:255];
    logic [7:0] rx_wr = '0, rx_rd = '0;
    int  pops = 0, sel_rises = 0;

    assign spi_rx_level = rx_wr - rx_rd;

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 ^ (i * 32'h0101_0103);
    endfunction

    function automatic logic [7:0] rxb(input int k);
        return 8'(k * 7 + 3);
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rx_pend) begin rx_rd = rx_rd + 1'b1; rx_pend = 0; end
        spi_rx_data = rx_q[rx_rd];
        spi_tx_full = tx_stall && (cyc % 3 == 0);
        fb_full     = fb_stall && (cyc % 5 < 2);
        mem_ack = 1'b0;
        mem_rvalid = 1'b0;
        if (rd_left > 0) begin
            if (rgap && gap_t) gap_t = 0;
            else begin
                gap_t = 1; mem_rvalid = 1'b1; mem_rdata = mem[rd_idx];
                rd_idx = rd_idx + 1'b1; rd_left--;
            end
        end
        if (ack_pend) begin
            if (ack_dly == 0) begin
                mem_ack = 1'b1; ack_pend = 0;
                if (req_we) wr_idx = req_idx;
                else begin rd_idx = req_idx; rd_left = 8; gap_t = 0; end
            end else ack_dly--;
        end
        #1;
        if (mem_req && !mem_ack && !ack_pend) begin
            ack_pend = 1; ack_dly = ack_lat; req_we = mem_we; req_idx = mem_addr[10:2];
        end
        if (mem_wvalid) begin mem[wr_idx] = mem_wdata; wr_idx = wr_idx + 1'b1; end
        if (spi_tx_push) begin tx_log[tx_n[7:0]] = spi_tx_data; tx_n++; end
        if (spi_rx_pop) begin rx_pend = 1; pops++; end
        if (fb_push) begin fb_la[fb_n[5:0]] = fb_addr; fb_ld[fb_n[5:0]] = fb_data; fb_n++; end
        if (port_sel && !sel_prev) sel_rises++;
        sel_prev = port_sel;
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_logs();
        tx_n = 0; fb_n = 0; pops = 0; sel_rises = 0;
    endtask

    task automatic start_job(input logic [1:0] m, input logic [31:0] s, input logic [31:0] d,
                             input logic [31:0] c, input logic [2:0] id);
        @(negedge clk);
        job_mode = m; job_src = s; job_dst = d; job_count = c; job_spi_id = id;
        job_start = 1'b1;
        @(negedge clk);
        job_start = 1'b0;
    endtask

    task automatic wait_done(input string tag, output int dones);
        int t = 0;
        dones = 0;
        while (t < 4000) begin
            @(negedge clk); #2; t++;
            if (job_done) begin
                dones++;
                chk(job_busy == 1'b0, {tag, " R9 busy low with done"}, 32'(job_busy), 0);
                @(negedge clk); #2;
                if (job_done) dones++;
                break;
            end
        end
        if (t >= 4000) chk(0, {tag, " R9 completion timeout"}, 32'(t), 0);
    endtask

    task automatic t_reset();
        #2;
        chk(job_busy == 0, "R1 busy after reset", 32'(job_busy), 0);
        chk(job_done == 0, "R1 done after reset", 32'(job_done), 0);
        chk({mem_req, mem_wvalid, spi_tx_push, spi_rx_pop, fb_push, port_sel} == 0,
            "R1 outputs quiet after reset",
            32'({mem_req, mem_wvalid, spi_tx_push, spi_rx_pop, fb_push, port_sel}), 0);
    endtask

    task automatic t_mem2mem();
        int dones, bad = 0;
        clear_logs(); ack_lat = 2; rgap = 1;
        start_job(2'd0, 32'h000, 32'h200, 32'd64, 3'd0);
        wait_done("m2m", dones);
        for (int k = 0; k < 16; k++) if (mem[128 + k] != pat(k)) bad++;
        chk(bad == 0, "R3 R4 copied words", 32'(bad), 0);
        chk(mem[144] == pat(144), "R3 word past destination untouched", mem[144], pat(144));
        chk(dones == 1, "R9 single done pulse m2m", 32'(dones), 1);
        ack_lat = 0; rgap = 0;
    endtask

    task automatic t_mem2spi();
        int dones, bad = 0;
        clear_logs(); tx_stall = 1; ack_lat = 1;
        start_job(2'd1, 32'h080, 32'h0, 32'd64, 3'd5);
        #2;
        chk(job_busy == 1, "R2 busy after start", 32'(job_busy), 1);
        chk(spi_id == 3'd5, "R5 spi id passed through", 32'(spi_id), 5);
        wait_done("m2spi", dones);
        chk(tx_n == 64, "R5 bytes pushed", 32'(tx_n), 64);
        for (int k = 0; k < 64; k++)
            if (tx_log[k] != 8'(pat(32 + k / 4) >> (8 * (k % 4)))) bad++;
        chk(bad == 0, "R5 byte order", 32'(bad), 0);
        chk(sel_rises == 2, "R6 port select per chunk", 32'(sel_rises), 2);
        chk(dones == 1, "R9 single done pulse m2spi", 32'(dones), 1);
        tx_stall = 0; ack_lat = 0;
    endtask

    task automatic t_spi2mem();
        int dones, bad = 0;
        clear_logs();
        rx_wr = '0; rx_rd = '0;
        for (int k = 0; k < 20; k++) begin rx_q[k] = rxb(k); end
        rx_wr = 8'd20;
        start_job(2'd2, 32'h0, 32'h300, 32'd64, 3'd2);
        repeat (40) @(negedge clk);
        #2;
        chk(pops == 0, "R7 no pop below a chunk", 32'(pops), 0);
        chk(job_busy == 1 && mem_req == 0, "R7 waiting without memory request",
            32'({job_busy, mem_req}), 32'b10);
        for (int k = 20; k < 64; k++) rx_q[k] = rxb(k);
        rx_wr = 8'd64;
        wait_done("spi2m", dones);
        chk(pops == 64, "R7 bytes popped", 32'(pops), 64);
        for (int i = 0; i < 16; i++)
            if (mem[192 + i] != {rxb(4*i+3), rxb(4*i+2), rxb(4*i+1), rxb(4*i)}) bad++;
        chk(bad == 0, "R7 packed words in memory", 32'(bad), 0);
        chk(sel_rises == 2, "R6 port select per chunk rx", 32'(sel_rises), 2);
    endtask

    task automatic t_mem2fb();
        int dones, bad = 0;
        clear_logs(); fb_stall = 1;
        start_job(2'd3, 32'h100, 32'h1EC0_0040, 32'd96, 3'd0);
        wait_done("m2fb", dones);
        chk(fb_n == 24, "R8 words pushed", 32'(fb_n), 24);
        for (int i = 0; i < 24; i++)
            if (fb_la[i] != 32'h1EC0_0040 + 32'(4 * i) || fb_ld[i] != pat(64 + i)) bad++;
        chk(bad == 0, "R8 framebuffer address and data", 32'(bad), 0);
        chk(sel_rises == 3, "R6 port select per chunk fb", 32'(sel_rises), 3);
        fb_stall = 0;
    endtask

    task automatic t_busy_start();
        int dones, bad = 0;
        clear_logs(); ack_lat = 3;
        start_job(2'd0, 32'h000, 32'h380, 32'd32, 3'd1);
        repeat (4) @(negedge clk);
        job_mode = 2'd1; job_src = 32'h040; job_dst = 32'h3C0; job_count = 32'd64;
        job_start = 1'b1;
        @(negedge clk);
        job_start = 1'b0;
        wait_done("busy", dones);
        for (int k = 0; k < 8; k++) if (mem[224 + k] != pat(k)) bad++;
        chk(bad == 0, "R10 single chunk copied", 32'(bad), 0);
        chk(mem[232] == pat(232), "R10 nothing beyond one chunk", mem[232], pat(232));
        chk(tx_n == 0, "R2 start while busy pushed nothing", 32'(tx_n), 0);
        chk(mem[240] == pat(240), "R2 second destination untouched", mem[240], pat(240));
        chk(dones == 1, "R2 R9 one completion", 32'(dones), 1);
        repeat (10) @(negedge clk);
        #2;
        chk(job_busy == 0, "R2 no second job ran", 32'(job_busy), 0);
        ack_lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = pat(i);
        for (int i = 0; i < 256; i++) rx_q[i] = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem2mem();
        t_mem2spi();
        t_spi2mem();
        t_mem2fb();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule